// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes stereo PCM audio from a three-wire serial audio bus (bit clock, word clock and serial data) and turns each stereo frame into a pair of 32-bit samples. A 2-bit format select picks one of four framings at run time: I2S with 24-bit words, left-justified with up to 32 bits, and right-justified with 16 or 24 bits. The block serves a playback path that must accept whichever framing the upstream source uses, without needing a separate receiver for each one.

The three bus lines are asynchronous to the system clock. Each line passes through its own two-flop synchronizer. Rising edges of the bit clock are found by oversampling, and both data and word clock are read at those edges. A change of word clock level at a bit-clock rising edge marks the end of one word and the start of the next. The finished word is sign-extended, or for left-justified framing left-aligned, and held until its partner channel arrives. The pair is then presented with a single-cycle strobe. Format changes are only applied at a word boundary, and any half-built frame is dropped.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted and in the cycle after it, `valid_o` is 0 and both sample outputs are 0.
- R2: With format select 00 (I2S), a word clock of 0 carries the left word and 1 carries the right word. The MSB arrives at the second bit-clock rising edge after the word clock changes. The first 24 bits are taken and sign-extended from bit 23, and any later bits in the slot are ignored.
- R3: With format select 01 (left-justified), a word clock of 1 carries the left word. The MSB arrives at the first bit-clock rising edge after the word clock changes. Up to the first 32 bits are placed from bit 31 downward, bits missing from a shorter slot read as 0, and bits past the 32nd are ignored.
- R4: With format select 10 (right-justified, 16-bit), a word clock of 1 carries the left word. The 16 bits just before the next word clock change are the sample, LSB last, sign-extended from bit 15. Earlier bits in the slot are ignored.
- R5: With format select 11 (right-justified, 24-bit), the rules of R4 apply with the last 24 bits, sign-extended from bit 23.
- R6: Each stereo frame, a left word followed by its right word, produces exactly one `valid_o` pulse lasting one cycle, with both samples presented in that cycle. Between pulses the sample outputs do not change.
- R7: After reset, the word in progress at the first word clock change is discarded. A right word with no captured left word before it produces no output.
- R8: A new format select value takes effect at the next word clock change. The word that ends there, and any left word held so far, are discarded. Output resumes with the next complete left/right pair.
- R9: All three bus lines are sampled only at rising edges of the synchronized bit clock. A `valid_o` pulse always follows, by one cycle, a word clock change seen at such an edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel_i | input | 2 | Framing select: 00 I2S-24, 01 left-justified, 10 right-justified 16, 11 right-justified 24 |
| bclk_i | input | 1 | Serial bit clock, asynchronous |
| wclk_i | input | 1 | Serial word clock (channel select), asynchronous |
| sdata_i | input | 1 | Serial data, MSB first |
| left_o | output | 32 | Left sample of the last completed frame |
| right_o | output | 32 | Right sample of the last completed frame |
| valid_o | output | 1 | One-cycle strobe when a new stereo pair is presented |

## Verification
Several rules are checked on every cycle by the assertions. These are: the strobe lasts a single cycle and always comes right after a word boundary, the sample outputs change only together with the strobe, the active format moves only at a word boundary, and reset leaves the outputs quiet. Only the bench scenarios can show that each framing picks the right bits. They also show that padding bits are ignored, that shorter or longer slots are handled, and that a stream joined part-way through, or a format switch in the middle of a frame, yields exactly the expected pairs and no extra ones.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

  localparam int WORD_W = 32;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  typedef enum logic [1:0] {
    FMT_I2S24 = 2'b00,
    FMT_LJ    = 2'b01,
    FMT_RJ16  = 2'b10,
    FMT_RJ24  = 2'b11
  } fmt_e;

  // Word-clock level that tags the left channel.
  function automatic logic left_level(fmt_e f);
    return (f != FMT_I2S24);
  endfunction

  // Sample width carried by each framing.
  function automatic logic [CNT_W-1:0] fmt_bits(fmt_e f);
    case (f)
      FMT_I2S24: return CNT_W'(24);
      FMT_LJ:    return CNT_W'(WORD_W);
      FMT_RJ16:  return CNT_W'(16);
      default:   return CNT_W'(24);
    endcase
  endfunction

  // MSB-anchored framings count bits from the word start.
  function automatic logic msb_first(fmt_e f);
    return (f == FMT_I2S24) || (f == FMT_LJ);
  endfunction

  // The bit seen at a word-clock change still belongs to the old word.
  function automatic logic late_lsb(fmt_e f);
    return (f == FMT_I2S24);
  endfunction

  // Left-align the cnt received bits, then sign-extend from width n.
  function automatic logic [WORD_W-1:0] take_msb(logic [WORD_W-1:0] sh,
                                                 logic [CNT_W-1:0] cnt,
                                                 logic [CNT_W-1:0] n);
    logic [WORD_W-1:0]        aligned;
    logic signed [WORD_W-1:0] s;
    aligned = sh << (CNT_W'(WORD_W) - cnt);
    s = $signed(aligned);
    s = s >>> (CNT_W'(WORD_W) - n);
    return $unsigned(s);
  endfunction

  // Keep the newest n bits and sign-extend them.
  function automatic logic [WORD_W-1:0] take_lsb(logic [WORD_W-1:0] sh,
                                                 logic [CNT_W-1:0] n);
    logic signed [WORD_W-1:0] s;
    s = $signed(sh << (CNT_W'(WORD_W) - n));
    s = s >>> (CNT_W'(WORD_W) - n);
    return $unsigned(s);
  endfunction

endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_i[g]};
    end
    assign sync_o[g] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/sarx_edge.sv
module sarx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;

endmodule

// File: rtl/sarx_slot.sv
module sarx_slot
  import sarx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick_i,
  input  logic              word_edge_i,
  input  fmt_e              fmt_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);

  logic [WORD_W-1:0] sh_q,  sh_app;
  logic [CNT_W-1:0]  cnt_q, cnt_app;
  logic              shift_ok;
  logic [WORD_W-1:0] src_sh;
  logic [CNT_W-1:0]  src_cnt;

  // Register state after appending the current bit.
  always_comb begin
    shift_ok = !msb_first(fmt_i) || (cnt_q < fmt_bits(fmt_i));
    sh_app   = shift_ok ? {sh_q[WORD_W-2:0], bit_i} : sh_q;
    cnt_app  = (shift_ok && (cnt_q != CNT_W'(WORD_W))) ? cnt_q + 1'b1 : cnt_q;
  end

  // The word closed at this edge, with or without the current bit.
  always_comb begin
    src_sh  = late_lsb(fmt_i) ? sh_app  : sh_q;
    src_cnt = late_lsb(fmt_i) ? cnt_app : cnt_q;
    word_o  = msb_first(fmt_i) ? take_msb(src_sh, src_cnt, fmt_bits(fmt_i))
                               : take_lsb(src_sh, fmt_bits(fmt_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (bit_tick_i && word_edge_i) begin
      if (late_lsb(fmt_i)) begin
        sh_q  <= '0;
        cnt_q <= '0;
      end else begin
        sh_q  <= {{(WORD_W-1){1'b0}}, bit_i};
        cnt_q <= CNT_W'(1);
      end
    end else if (bit_tick_i) begin
      sh_q  <= sh_app;
      cnt_q <= cnt_app;
    end
  end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sarx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        fmt_sel_i,
  input  logic              bclk_i,
  input  logic              wclk_i,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);

  localparam int LN_BCLK = 2;
  localparam int LN_WCLK = 1;
  localparam int LN_DATA = 0;

  logic [2:0]        pins_s;
  logic              bclk_rise_w;
  logic              boundary_w;
  logic              fmt_switch_w;
  logic              capture_w;
  logic              was_left_w;
  fmt_e              fmt_req, fmt_eff;
  logic [WORD_W-1:0] word_w;

  fmt_e              fmt_act_q;
  logic              wck_prev_q, wck_seen_q, armed_q, have_left_q, valid_q;
  logic [WORD_W-1:0] left_hold_q, left_q, right_q;

  sarx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({bclk_i, wclk_i, sdata_i}),
    .sync_o  (pins_s)
  );

  sarx_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (pins_s[LN_BCLK]),
    .rise_o  (bclk_rise_w)
  );

  assign fmt_req      = fmt_e'(fmt_sel_i);
  assign boundary_w   = bclk_rise_w && wck_seen_q && (pins_s[LN_WCLK] != wck_prev_q);
  assign fmt_switch_w = boundary_w && (fmt_req != fmt_act_q);
  assign fmt_eff      = fmt_switch_w ? fmt_req : fmt_act_q;
  assign capture_w    = boundary_w && !fmt_switch_w && armed_q;
  assign was_left_w   = (wck_prev_q == left_level(fmt_act_q));

  sarx_slot u_slot (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_tick_i  (bclk_rise_w),
    .word_edge_i (boundary_w),
    .fmt_i       (fmt_eff),
    .bit_i       (pins_s[LN_DATA]),
    .word_o      (word_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_act_q   <= FMT_I2S24;
      wck_prev_q  <= 1'b0;
      wck_seen_q  <= 1'b0;
      armed_q     <= 1'b0;
      have_left_q <= 1'b0;
      valid_q     <= 1'b0;
      left_hold_q <= '0;
      left_q      <= '0;
      right_q     <= '0;
    end else begin
      valid_q <= 1'b0;
      if (bclk_rise_w) begin
        wck_prev_q <= pins_s[LN_WCLK];
        wck_seen_q <= 1'b1;
      end
      if (boundary_w) armed_q <= 1'b1;
      if (fmt_switch_w) begin
        fmt_act_q   <= fmt_req;
        have_left_q <= 1'b0;
      end
      if (capture_w) begin
        if (was_left_w) begin
          left_hold_q <= word_w;
          have_left_q <= 1'b1;
        end else if (have_left_q) begin
          left_q      <= left_hold_q;
          right_q     <= word_w;
          valid_q     <= 1'b1;
          have_left_q <= 1'b0;
        end
      end
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/sarx_chk.sv
module sarx_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         valid_o,
  input logic [W-1:0] left_o,
  input logic [W-1:0] right_o,
  input logic         bclk_rise,
  input logic         boundary,
  input logic [1:0]   fmt_act
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!valid_o && left_o == '0 && right_o == '0));

  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R6
  left_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(left_o) |-> valid_o);

  // R6
  right_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(right_o) |-> valid_o);

  // R8
  fmt_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fmt_act) |-> $past(boundary));

  // R9
  strobe_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(boundary));

  // R9
  rise_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_rise |=> !bclk_rise);

endmodule

bind serial_audio_rx sarx_chk #(.W(32)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .valid_o   (valid_o),
  .left_o    (left_o),
  .right_o   (right_o),
  .bclk_rise (bclk_rise_w),
  .boundary  (boundary_w),
  .fmt_act   (fmt_act_q)
);

// File: tb/tb_serial_audio_rx.sv
module tb_serial_audio_rx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt_sel = 2'b00;
  logic        bclk = 1'b0, wclk = 1'b0, sdata = 1'b0;
  logic [31:0] left_o, right_o;
  logic        valid_o;

  always #2 clk = ~clk;

  serial_audio_rx dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .fmt_sel_i (fmt_sel),
    .bclk_i    (bclk),
    .wclk_i    (wclk),
    .sdata_i   (sdata),
    .left_o    (left_o),
    .right_o   (right_o),
    .valid_o   (valid_o)
  );

  int checks = 0, errors = 0;
  logic        ws_q[$];
  logic        d_q[$];
  logic [63:0] exp_q[$];
  string       tag_q[$];
  int          chg_at = -1;
  logic [1:0]  chg_fmt = 2'b00;
  logic [63:0] cur_exp;
  string       cur_tag;

  function automatic logic [31:0] sext_n(logic [31:0] v, int n);
    logic [31:0] r;
    for (int b = 0; b < 32; b++) r[b] = (b < n) ? v[b] : v[n-1];
    return r;
  endfunction

  function automatic int width_of(logic [1:0] f);
    case (f)
      2'b00:   return 24;
      2'b01:   return 32;
      2'b10:   return 16;
      default: return 24;
    endcase
  endfunction

  function automatic logic [31:0] expect_word(logic [1:0] f, int slot, logic [31:0] v);
    logic [31:0] r;
    r = v;
    if (f == 2'b01) begin
      for (int b = 0; b < 32; b++) if (b < 32 - slot) r[b] = 1'b0;
      return r;
    end
    return sext_n(v, width_of(f));
  endfunction

  function automatic logic slot_bit(logic [1:0] f, int slot, int k,
                                    logic [31:0] v, logic [31:0] junk);
    int w;
    w = width_of(f);
    if (f[1]) begin
      if (k >= slot - w) return v[w-1-(k-(slot-w))];
      return junk[k % 32];
    end
    if (k < w) return v[w-1-k];
    return junk[k % 32];
  endfunction

  task automatic add_slot(logic [1:0] f, int slot, logic lvl, logic [31:0] v);
    for (int k = 0; k < slot; k++) begin
      ws_q.push_back(lvl);
      d_q.push_back(slot_bit(f, slot, k, v, $urandom()));
    end
  endtask

  task automatic add_frame(logic [1:0] f, int slot, logic [31:0] lv, logic [31:0] rv,
                           bit expect_it, string tag);
    logic lvl;
    lvl = (f != 2'b00);
    add_slot(f, slot, lvl, lv);
    add_slot(f, slot, !lvl, rv);
    if (expect_it) begin
      exp_q.push_back({expect_word(f, slot, lv), expect_word(f, slot, rv)});
      tag_q.push_back(tag);
    end
  endtask

  task automatic add_idle(logic lvl, int n, bit rand_data);
    for (int k = 0; k < n; k++) begin
      ws_q.push_back(lvl);
      d_q.push_back(rand_data ? 1'($urandom()) : 1'b0);
    end
  endtask

  // Data and word clock change with the bit clock's falling edge so that
  // the receiver's rising-edge sampling (R9) sees settled values.
  task automatic play(bit lead);
    for (int i = 0; i < ws_q.size(); i++) begin
      @(negedge clk);
      if (i == chg_at) fmt_sel = chg_fmt;
      bclk  = 1'b0;
      wclk  = (lead && (i + 1 < ws_q.size())) ? ws_q[i+1] : ws_q[i];
      sdata = d_q[i];
      repeat (6) @(negedge clk);
      bclk = 1'b1;
      repeat (5) @(negedge clk);
    end
    @(negedge clk);
    bclk = 1'b0;
    repeat (40) @(negedge clk);
    ws_q.delete();
    d_q.delete();
    chg_at = -1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    bclk = 1'b0;
    sdata = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic end_check(string tag);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s missing pairs: actual pending=%0d expected 0", tag, exp_q.size());
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  task automatic scenario(logic [1:0] f, int slot, int n, string tag);
    logic left_lvl;
    left_lvl = (f != 2'b00);
    do_reset();
    fmt_sel = f;
    wclk = !left_lvl;
    add_idle(!left_lvl, 2, 0);
    add_frame(f, slot, 32'h8080_8000, 32'h7f7f_7fff, 1, tag);
    for (int j = 0; j < n; j++) add_frame(f, slot, $urandom(), $urandom(), 1, tag);
    add_idle(left_lvl, 3, 0);
    play(f == 2'b00);
    end_check(tag);
  endtask

  // Pair monitor: every strobe must match the next expected pair (R6).
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R6 unexpected strobe: actual L=%h R=%h expected none", left_o, right_o);
      end else begin
        cur_exp = exp_q.pop_front();
        cur_tag = tag_q.pop_front();
        if ({left_o, right_o} !== cur_exp) begin
          errors++;
          $display("FAIL %s pair: actual L=%h R=%h expected L=%h R=%h",
                   cur_tag, left_o, right_o, cur_exp[63:32], cur_exp[31:0]);
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20531));
    do_reset();
    // R1: quiet outputs after reset
    checks++;
    if (valid_o !== 1'b0) begin
      errors++; $display("FAIL R1 valid: actual %b expected 0", valid_o);
    end
    checks++;
    if (left_o !== 32'h0 || right_o !== 32'h0) begin
      errors++; $display("FAIL R1 samples: actual %h/%h expected 0/0", left_o, right_o);
    end

    scenario(2'b00, 32, 5, "R2 i2s slot32");
    scenario(2'b00, 24, 2, "R2 i2s slot24");
    scenario(2'b01, 32, 5, "R3 lj slot32");
    scenario(2'b01, 24, 2, "R3 lj slot24");
    scenario(2'b01, 40, 2, "R3 lj slot40");
    scenario(2'b10, 32, 4, "R4 rj16 slot32");
    scenario(2'b10, 16, 2, "R4 rj16 slot16");
    scenario(2'b11, 32, 4, "R5 rj24 slot32");
    scenario(2'b11, 24, 2, "R5 rj24 slot24");

    // R7: join mid-stream: partial left word and lone right word give nothing
    do_reset();
    fmt_sel = 2'b01;
    wclk = 1'b1;
    add_idle(1'b1, 5, 1);
    add_slot(2'b01, 32, 1'b0, $urandom());
    add_frame(2'b01, 32, $urandom(), $urandom(), 1, "R7 mid-stream join");
    add_frame(2'b01, 32, $urandom(), $urandom(), 1, "R7 mid-stream join");
    add_idle(1'b1, 3, 0);
    play(0);
    end_check("R7 mid-stream join");

    // R8: switch from left-justified to right-justified 16 mid-left-word
    do_reset();
    fmt_sel = 2'b01;
    wclk = 1'b0;
    add_idle(1'b0, 2, 0);
    add_frame(2'b01, 32, $urandom(), $urandom(), 1, "R8 before switch");
    chg_at = ws_q.size() + 10;
    chg_fmt = 2'b10;
    add_frame(2'b10, 32, $urandom(), $urandom(), 0, "R8 dropped");
    add_frame(2'b10, 32, $urandom(), $urandom(), 1, "R8 after switch");
    add_frame(2'b10, 32, 32'h0000_8001, 32'h0000_7ffe, 1, "R8 after switch");
    add_idle(1'b1, 3, 0);
    play(0);
    end_check("R8 format switch");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule